// File: doc/BRIEF.md
# Interrupt Controller with Periodic Timer

This block collects interrupt requests for a small 8-bit processor and drives a single level-sensitive interrupt line to it. It keeps eight request flags with one enable flag each. Three flags are raised by hardware: a periodic timer, a pulse that marks the end of a radio transmission, and a pulse that marks the end of a serial converter access. Three more flags are raised only by software. The remaining two positions are not implemented.

The processor reaches the block through a byte-wide register port with an address, a write strobe and a read strobe. The requests are read from one location and the enables from the next. Two write-only locations act on the request flags bit by bit: one clears, the other sets. A fifth location holds the timer period, counted in rising edges of a slow reference clock. The reference clock is brought into the system clock domain inside the block.

The timer counts reference edges and raises request 0 once per period. It reloads itself each time it does so. A period of zero stops it. The interrupt line stays high while any enabled request is pending, so software must clear the request it has serviced.

Top module: `irqc_top`

## Requirements
- R1: After reset the request flags, the enable flags and the timer period are all zero, and the interrupt line is low.
- R2: A one-cycle pulse on `xmit_done_i` sets request bit 1, and a one-cycle pulse on `conv_done_i` sets request bit 2. The request flags are read at address 0.
- R3: The enable register is at address 1 and reads back what was written. The interrupt line is the OR over all bits of request AND enable.
- R4: Writing to address 2 clears each request whose data bit is 1 and leaves requests whose data bit is 0 unchanged.
- R5: Writing to address 3 sets each implemented request whose data bit is 1. Software raises the general-purpose requests in bits 5, 6 and 7 this way.
- R6: Request bits 3 and 4 always read as 0, even after a write of 1 to those positions at address 3.
- R7: When a hardware event arrives in the same cycle as a clear write to its bit, the request ends up set.
- R8: The period register at address 4 reads back what was written. With a non-zero period P, the timer sets request bit 0 once every P rising edges of `ref_clk_i`, and the count restarts when the period is written.
- R9: With a period of 0 the timer never sets request bit 0.
- R10: The interrupt line stays high while an enabled request is pending, and falls only once that request is cleared.
- R11: Read data appears on `rd_data_o` one cycle after `rd_en_i`. Unmapped addresses and the two write-only locations read 0. A write to address 0 does not change the requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ref_clk_i | input | 1 | Slow reference clock, sampled and edge-detected internally |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data, registered |
| xmit_done_i | input | 1 | Transmit-complete event pulse |
| conv_done_i | input | 1 | Serial-conversion-complete event pulse |
| irq_o | output | 1 | Interrupt line to the processor |

## Verification
Several properties are checked on every cycle. Requests hold their value when no event, set or clear occurs. A hardware event leaves its flag set on the next cycle, even when a clear is written in the same cycle. A clear write empties every flag it names that no event touches at the same time. The timer count moves only on reference ticks or period loads, and an asserted interrupt line cannot drop without a clear or an enable write. The bench scenarios show the rest: the exact spacing of timer requests in reference edges, the register read-back values, the fixed zero in bits 3 and 4, and the silence of a stopped timer.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
   // request bit positions decoded by the processor's service routine
   localparam int unsigned BIT_TIMER = 0;
   localparam int unsigned BIT_XMIT  = 1;
   localparam int unsigned BIT_CONV  = 2;

   // register selection
   typedef enum logic [2:0] {
      REG_PEND   = 3'd0,
      REG_ENABLE = 3'd1,
      REG_CLEAR  = 3'd2,
      REG_RAISE  = 3'd3,
      REG_PERIOD = 3'd4
   } reg_sel_e;
endpackage

// File: rtl/irqc_ref_sync.sv
`timescale 1ns/1ps
module irqc_ref_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic ref_clk_i,
   output logic tick_o
);
   localparam int unsigned CHAIN = STAGES + 1;

   logic [CHAIN-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         initial $fatal(1, "irqc_ref_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < CHAIN; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk_i) begin
               if (!rst_ni) chain_q[s] <= 1'b0;
               else         chain_q[s] <= ref_clk_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i) begin
               if (!rst_ni) chain_q[s] <= 1'b0;
               else         chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   // rising edge of the synchronized reference
   assign tick_o = chain_q[CHAIN-2] & ~chain_q[CHAIN-1];
endmodule

// File: rtl/irqc_timer.sv
`timescale 1ns/1ps
module irqc_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic [CNT_W-1:0] period_i,
   output logic             fire_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] count_q;
   logic             running;
   logic             expire;

   generate
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_width
         initial $fatal(1, "irqc_timer: CNT_W out of range");
      end
   endgenerate

   assign running = (period_i != '0);
   assign expire  = tick_i && running && (count_q <= ONE);
   assign fire_o  = expire;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         count_q <= '0;
      end else if (load_i) begin
         count_q <= load_val_i;
      end else if (tick_i) begin
         if (!running)    count_q <= '0;
         else if (expire) count_q <= period_i;
         else             count_q <= count_q - ONE;
      end
   end

   // R8: count moves only on a tick or a load
   a_r8_count_hold : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_i && !load_i) |=> $stable(count_q));
   // R9: a stopped timer with an empty count stays empty
   a_r9_stopped_idle : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && period_i == '0 && count_q == '0) |=> (count_q == '0));
endmodule

// File: rtl/irqc_req_bank.sv
`timescale 1ns/1ps
module irqc_req_bank #(
   parameter int unsigned         N_REQ    = 8,
   parameter logic [N_REQ-1:0]    IMPL_MSK = 8'hE7
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [N_REQ-1:0] hw_evt_i,
   input  logic             clr_stb_i,
   input  logic             set_stb_i,
   input  logic [N_REQ-1:0] data_i,
   output logic [N_REQ-1:0] req_o
);
   logic [N_REQ-1:0] req_q;

   generate
      if (N_REQ < 1 || N_REQ > 32) begin : g_bad_n
         initial $fatal(1, "irqc_req_bank: N_REQ out of range");
      end
      for (genvar k = 0; k < N_REQ; k++) begin : g_bit
         if (IMPL_MSK[k]) begin : g_live
            always_ff @(posedge clk_i) begin
               if (!rst_ni)
                  req_q[k] <= 1'b0;
               else if (hw_evt_i[k] || (set_stb_i && data_i[k]))
                  req_q[k] <= 1'b1;   // events take priority over clears
               else if (clr_stb_i && data_i[k])
                  req_q[k] <= 1'b0;
            end
         end else begin : g_tied
            assign req_q[k] = 1'b0;
         end
      end
   endgenerate

   assign req_o = req_q;

   // R7 / R2: an implemented event always leaves its flag set
   a_r7_event_wins : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(hw_evt_i & IMPL_MSK)) |=>
      ((req_o & $past(hw_evt_i & IMPL_MSK)) == $past(hw_evt_i & IMPL_MSK)));
   // R4: a clear empties every named flag not hit by an event
   a_r4_clear_named : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_stb_i && !set_stb_i) |=> ((req_o & $past(data_i) & ~$past(hw_evt_i)) == '0));
   // R4 / R11: flags hold without event, set or clear
   a_r4_hold : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_stb_i && !set_stb_i && hw_evt_i == '0) |=> $stable(req_o));
endmodule

// File: rtl/irqc_top.sv
`timescale 1ns/1ps
module irqc_top #(
   parameter int unsigned      DATA_W      = 8,
   parameter int unsigned      ADDR_W      = 3,
   parameter int unsigned      PER_W       = 8,
   parameter int unsigned      SYNC_STAGES = 2,
   parameter logic [DATA_W-1:0] IMPL_MSK   = 8'hE7
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ref_clk_i,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] rd_data_o,
   input  logic              xmit_done_i,
   input  logic              conv_done_i,
   output logic              irq_o
);
   import irqc_pkg::*;

   localparam int unsigned PAD_W = DATA_W - PER_W;

   logic              tick;
   logic              fire;
   logic [DATA_W-1:0] hw_evt;
   logic [DATA_W-1:0] req;
   logic [DATA_W-1:0] enable_q;
   logic [PER_W-1:0]  period_q;
   logic [DATA_W-1:0] period_rd;
   logic [DATA_W-1:0] rd_mux;
   logic              sel_en, sel_clr, sel_set, sel_per;
   logic              clr_stb, set_stb, en_stb, per_stb;

   generate
      if (DATA_W < 3) begin : g_bad_data
         initial $fatal(1, "irqc_top: DATA_W must hold the three event bits");
      end
      if (PER_W > DATA_W) begin : g_bad_per
         initial $fatal(1, "irqc_top: PER_W must fit in one data word");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         initial $fatal(1, "irqc_top: ADDR_W must be at least 3");
      end
      if (PAD_W > 0) begin : g_per_pad
         assign period_rd = {{PAD_W{1'b0}}, period_q};
      end else begin : g_per_full
         assign period_rd = period_q;
      end
   endgenerate

   // address decode
   assign sel_en  = (addr_i == ADDR_W'(REG_ENABLE));
   assign sel_clr = (addr_i == ADDR_W'(REG_CLEAR));
   assign sel_set = (addr_i == ADDR_W'(REG_RAISE));
   assign sel_per = (addr_i == ADDR_W'(REG_PERIOD));
   assign en_stb  = wr_en_i && sel_en;
   assign clr_stb = wr_en_i && sel_clr;
   assign set_stb = wr_en_i && sel_set;
   assign per_stb = wr_en_i && sel_per;

   irqc_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ref_clk_i (ref_clk_i),
      .tick_o    (tick)
   );

   irqc_timer #(.CNT_W(PER_W)) u_timer (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick),
      .load_i     (per_stb),
      .load_val_i (wr_data_i[PER_W-1:0]),
      .period_i   (period_q),
      .fire_o     (fire)
   );

   always_comb begin
      hw_evt           = '0;
      hw_evt[BIT_TIMER] = fire;
      hw_evt[BIT_XMIT]  = xmit_done_i;
      hw_evt[BIT_CONV]  = conv_done_i;
   end

   irqc_req_bank #(.N_REQ(DATA_W), .IMPL_MSK(IMPL_MSK)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .hw_evt_i  (hw_evt),
      .clr_stb_i (clr_stb),
      .set_stb_i (set_stb),
      .data_i    (wr_data_i),
      .req_o     (req)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         enable_q <= '0;
         period_q <= '0;
      end else begin
         if (en_stb)  enable_q <= wr_data_i;
         if (per_stb) period_q <= wr_data_i[PER_W-1:0];
      end
   end

   always_comb begin
      unique case (addr_i)
         ADDR_W'(REG_PEND):   rd_mux = req;
         ADDR_W'(REG_ENABLE): rd_mux = enable_q;
         ADDR_W'(REG_PERIOD): rd_mux = period_rd;
         default:             rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)      rd_data_o <= '0;
      else if (rd_en_i) rd_data_o <= rd_mux;
   end

   assign irq_o = |(req & enable_q);

   // R10: the line cannot drop unless software clears or disables
   a_r10_irq_holds : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o && !clr_stb && !en_stb) |=> irq_o);
   // R1: the line is low in the first cycle after reset
   a_r1_reset_quiet : assert property (@(posedge clk_i)
      !rst_ni |=> !irq_o);
endmodule

// File: tb/irqc_top_test.sv
`timescale 1ns/1ps
module irqc_top_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_clk = 1'b0;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [2:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       xmit = 1'b0, conv = 1'b0;
   logic       irq;
   int         n_run = 0, n_fail = 0;
   int         cyc = 0;

   irqc_top uut (
      .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk),
      .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
      .wr_data_i(wdata), .rd_data_o(rdata),
      .xmit_done_i(xmit), .conv_done_i(conv), .irq_o(irq)
   );

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // reference clock: rising edge every 8 system cycles
   initial begin
      forever begin
         repeat (4) @(negedge clk);
         ref_clk = ~ref_clk;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic wait_rise(output int t);
      t = -1;
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         if (irq) begin t = cyc; break; end
      end
   endtask

   task automatic t_reset();
      logic [7:0] d;
      check("R1 irq", irq, 0);
      rd(3'd0, d); check("R1 pend", d, 8'h00);
      rd(3'd1, d); check("R1 enable", d, 8'h00);
      rd(3'd4, d); check("R1 period", d, 8'h00);
   endtask

   task automatic t_events();
      logic [7:0] d;
      @(negedge clk); xmit = 1'b1; @(negedge clk); xmit = 1'b0;
      rd(3'd0, d); check("R2 xmit bit1", d, 8'h02);
      @(negedge clk); conv = 1'b1; @(negedge clk); conv = 1'b0;
      rd(3'd0, d); check("R2 conv bit2", d, 8'h06);
      check("R3 irq off while disabled", irq, 0);
   endtask

   task automatic t_mask_clear();
      logic [7:0] d;
      wr(3'd1, 8'h04);
      rd(3'd1, d); check("R3 enable readback", d, 8'h04);
      check("R3 irq on", irq, 1);
      wr(3'd2, 8'h02);
      rd(3'd0, d); check("R4 clear bit1 only", d, 8'h04);
      check("R3 irq follows bit2", irq, 1);
      wr(3'd2, 8'h00);
      rd(3'd0, d); check("R4 zero clear no effect", d, 8'h04);
      wr(3'd0, 8'h00);
      rd(3'd0, d); check("R11 write to pend ignored", d, 8'h04);
      wr(3'd2, 8'h04);
      check("R3 irq drops", irq, 0);
   endtask

   task automatic t_set();
      logic [7:0] d;
      wr(3'd3, 8'hF8);
      rd(3'd0, d); check("R5 gp set", d, 8'hE0);
      check("R6 bits3-4 zero", int'(d[4:3]), 0);
      wr(3'd2, 8'hFF);
      rd(3'd0, d); check("R4 clear all", d, 8'h00);
   endtask

   task automatic t_level();
      wr(3'd1, 8'h20);
      wr(3'd3, 8'h20);
      repeat (20) @(negedge clk);
      check("R10 held", irq, 1);
      wr(3'd2, 8'h20);
      check("R10 cleared", irq, 0);
   endtask

   task automatic t_collide();
      logic [7:0] d;
      wr(3'd3, 8'h02);
      @(negedge clk);
      wr_en = 1'b1; addr = 3'd2; wdata = 8'h02; xmit = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0; xmit = 1'b0;
      rd(3'd0, d); check("R7 event beats clear", d, 8'h02);
      wr(3'd2, 8'hFF);
   endtask

   task automatic t_unmapped();
      logic [7:0] d;
      rd(3'd5, d); check("R11 unmapped", d, 8'h00);
      rd(3'd2, d); check("R11 clear reads 0", d, 8'h00);
      rd(3'd3, d); check("R11 set reads 0", d, 8'h00);
   endtask

   task automatic t_timer();
      logic [7:0] d;
      int t1, t2, t3;
      repeat (100) @(negedge clk);
      rd(3'd0, d); check("R9 no fire at period 0", d, 8'h00);
      wr(3'd1, 8'h01);
      wr(3'd4, 8'd3);
      rd(3'd4, d); check("R8 period readback", d, 8'd3);
      wr(3'd2, 8'hFF);
      wait_rise(t1);
      wr(3'd2, 8'h01);
      wait_rise(t2);
      check("R8 interval 1", t2 - t1, 24);
      wr(3'd2, 8'h01);
      wait_rise(t3);
      check("R8 interval 2", t3 - t2, 24);
      wr(3'd4, 8'd0);
      wr(3'd2, 8'h01);
      repeat (200) @(negedge clk);
      check("R9 stopped irq", irq, 0);
      rd(3'd0, d); check("R9 stopped pend", d, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_reset();
      t_events();
      t_mask_clear();
      t_set();
      t_level();
      t_collide();
      t_unmapped();
      t_timer();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule